// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block models a field-configurable two-level logic array. Sixteen inputs feed forty-eight AND terms, and any subset of those terms can be summed into each of eight outputs. A per-output polarity bit can invert each sum. Registers hold the configuration and model intact or blown links. A word-addressed synchronous write port loads them. Each write to a term supplies that term's 32 AND-link bits and 8 OR-link bits. A separate write loads the polarity byte. A lock input refuses all writes, which models links that can only be programmed once.

Evaluation from inputs to outputs is purely combinational. When the disable input is high, every output is switched off. The block reports this as an output-enable vector plus a forced data value, so no real tri-state nets are needed. A parameter selects the forced value: 0 for the tri-state style and all ones for the open-collector style, where a pull-up drives the line high.

The write decoder classifies each cycle as one of four kinds:
- `WR_IDLE`: no write this cycle.
- `WR_TERM`: a term write is accepted.
- `WR_POL`: a polarity write is accepted.
- `WR_REFUSED`: the write is locked, or its term index is out of range.

Only `WR_TERM` and `WR_POL` change state, and the change takes effect at the next rising clock edge.

Top module: `sop_logic_array`

## Requirements
- R1: After reset, every AND link is intact, every OR link is active and every polarity bit is 0 (active-high). With the outputs enabled, `f_val` therefore reads 8'h00 for any input, and `f_oe` reads 8'hFF.
- R2: AND link bit 2i keeps the true form of input i, and bit 2i+1 keeps its complement (1 = intact). True-only means the term needs input i = 1. Complement-only means the term needs input i = 0. With both links blown, input i does not affect the term.
- R3: If both links of any input pair of a term are intact, that term evaluates to 0 for every input value.
- R4: OR link bit o of a term (1 = active) includes that term in output o. Output o is the OR of its included terms, and with no included term true it is 0.
- R5: Polarity bit o set to 1 inverts output o (active-low). Set to 0, the sum passes unchanged.
- R6: While `out_off` is 1, `f_oe` is 8'h00. `f_val` is 8'h00 for the tri-state style (`OPEN_COLL`=0) and 8'hFF for the open-collector style (`OPEN_COLL`=1).
- R7: While `cfg_lock` is 1, term writes and polarity writes change nothing.
- R8: A term write whose index is 48 or more changes nothing. Index 47 is accepted.
- R9: A term write leaves the polarity bits unchanged, and a polarity write leaves the term links unchanged.
- R10: `f_val` follows a change of `in_vec` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low reset to the unprogrammed link state |
| cfg_we | input | 1 | Write strobe |
| cfg_pol_sel | input | 1 | 1 = the write loads polarity, 0 = the write loads a term |
| cfg_lock | input | 1 | 1 = refuse all writes |
| cfg_term | input | 6 | Index of the term being written |
| cfg_and | input | 32 | AND links of the term, two bits per input |
| cfg_or | input | 8 | OR links of the term, one bit per output |
| cfg_pol | input | 8 | Polarity bits, 1 = active-low |
| in_vec | input | 16 | Logic inputs |
| out_off | input | 1 | 1 = disable all outputs |
| f_val | output | 8 | Output data value |
| f_oe | output | 8 | Output enable, 1 = driven |

## Verification
The in-RTL assertions check several behaviours on every cycle:
- A term with a doubly intact pair is never true.
- A locked write, or a write to an out-of-range term, leaves the link state stable.
- Each kind of write leaves the other kind's registers stable.
- With no term true and the outputs enabled, every output equals its polarity bit.

Only the bench's scenarios can show the following:
- The true, complement and don't-care codes select the right input patterns.
- The OR routing sums the right terms.
- The disabled value differs between the two output styles.
- Outputs react to inputs within a cycle.
- The reset state reads as all zeros.

// File: rtl/sop_pkg.sv
package sop_pkg;
    typedef enum logic [1:0] {
        WR_IDLE,
        WR_TERM,
        WR_POL,
        WR_REFUSED
    } wr_kind_e;
endpackage

// File: rtl/sop_link_store.sv
module sop_link_store
    import sop_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8,
    localparam int TW    = $clog2(N_TERM),
    localparam int AW    = 2 * N_IN
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_pol,
    input  logic                              wr_lock,
    input  logic [TW-1:0]                     wr_idx,
    input  logic [AW-1:0]                     wr_and,
    input  logic [N_OUT-1:0]                  wr_or,
    input  logic [N_OUT-1:0]                  wr_polv,
    output logic [N_TERM-1:0][AW-1:0]         and_q,
    output logic [N_TERM-1:0][N_OUT-1:0]      or_q,
    output logic [N_OUT-1:0]                  pol_q
);
    localparam logic [TW-1:0] LAST_IDX = TW'(N_TERM - 1);

    wr_kind_e kind;
    logic     idx_ok;

    assign idx_ok = (wr_idx <= LAST_IDX);

    always_comb begin
        kind = WR_IDLE;
        unique case ({wr_en, wr_lock, wr_pol})
            3'b100:  kind = idx_ok ? WR_TERM : WR_REFUSED;
            3'b101:  kind = WR_POL;
            3'b110,
            3'b111:  kind = WR_REFUSED;
            default: kind = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            and_q <= '1;
            or_q  <= '1;
        end else if (kind == WR_TERM) begin
            for (int t = 0; t < N_TERM; t++) begin
                if (wr_idx == TW'(t)) begin
                    and_q[t] <= wr_and;
                    or_q[t]  <= wr_or;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= '0;
        end else if (kind == WR_POL) begin
            pol_q <= wr_polv;
        end
    end

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lock) |=> ($stable(and_q) && $stable(or_q) && $stable(pol_q)));

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_pol && !idx_ok) |=> ($stable(and_q) && $stable(or_q)));

    // R9
    pol_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_pol) |=> $stable(pol_q));

    // R9
    term_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pol) |=> ($stable(and_q) && $stable(or_q)));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    localparam int AW    = 2 * N_IN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           in_vec,
    input  logic [N_TERM-1:0][AW-1:0] links,
    output logic [N_TERM-1:0]         term
);
    logic [N_TERM-1:0] dead;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic acc;
        logic both;
        always_comb begin
            acc  = 1'b1;
            both = 1'b0;
            for (int i = 0; i < N_IN; i++) begin
                if (links[t][2*i])   acc = acc & in_vec[i];
                if (links[t][2*i+1]) acc = acc & ~in_vec[i];
                both = both | (links[t][2*i] & links[t][2*i+1]);
            end
        end
        assign term[t] = acc;
        assign dead[t] = both;
    end

    // R3
    dead_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead & term) == '0);
endmodule

// File: rtl/sop_or_stage.sv
module sop_or_stage #(
    parameter int N_TERM    = 48,
    parameter int N_OUT     = 8,
    parameter bit OPEN_COLL = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_TERM-1:0]            term,
    input  logic [N_TERM-1:0][N_OUT-1:0] route,
    input  logic [N_OUT-1:0]             pol,
    input  logic                         out_off,
    output logic [N_OUT-1:0]             f_val,
    output logic [N_OUT-1:0]             f_oe
);
    localparam logic [N_OUT-1:0] OFF_VAL = OPEN_COLL ? '1 : '0;

    logic [N_OUT-1:0] sum;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int t = 0; t < N_TERM; t++) begin
                hit = hit | (term[t] & route[t][o]);
            end
        end
        assign sum[o] = hit;
    end

    always_comb begin
        if (out_off) begin
            f_oe  = '0;
            f_val = OFF_VAL;
        end else begin
            f_oe  = '1;
            f_val = sum ^ pol;
        end
    end

    // R5
    idle_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_off && term == '0) |-> (f_val == pol));
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
    parameter int N_IN      = 16,
    parameter int N_TERM    = 48,
    parameter int N_OUT     = 8,
    parameter bit OPEN_COLL = 1'b0,
    localparam int TW       = $clog2(N_TERM),
    localparam int AW       = 2 * N_IN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_pol_sel,
    input  logic             cfg_lock,
    input  logic [TW-1:0]    cfg_term,
    input  logic [AW-1:0]    cfg_and,
    input  logic [N_OUT-1:0] cfg_or,
    input  logic [N_OUT-1:0] cfg_pol,
    input  logic [N_IN-1:0]  in_vec,
    input  logic             out_off,
    output logic [N_OUT-1:0] f_val,
    output logic [N_OUT-1:0] f_oe
);
    logic [N_TERM-1:0][AW-1:0]    and_q;
    logic [N_TERM-1:0][N_OUT-1:0] or_q;
    logic [N_OUT-1:0]             pol_q;
    logic [N_TERM-1:0]            term;

    sop_link_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_pol  (cfg_pol_sel),
        .wr_lock (cfg_lock),
        .wr_idx  (cfg_term),
        .wr_and  (cfg_and),
        .wr_or   (cfg_or),
        .wr_polv (cfg_pol),
        .and_q   (and_q),
        .or_q    (or_q),
        .pol_q   (pol_q)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vec (in_vec),
        .links  (and_q),
        .term   (term)
    );

    sop_or_stage #(.N_TERM(N_TERM), .N_OUT(N_OUT), .OPEN_COLL(OPEN_COLL)) u_or (
        .clk     (clk),
        .rst_n   (rst_n),
        .term    (term),
        .route   (or_q),
        .pol     (pol_q),
        .out_off (out_off),
        .f_val   (f_val),
        .f_oe    (f_oe)
    );
endmodule

// File: tb/sop_logic_array_bench.sv
`timescale 1ns/1ps
module sop_logic_array_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_pol_sel = 1'b0, cfg_lock = 1'b0;
    logic [5:0]  cfg_term = '0;
    logic [31:0] cfg_and = '0;
    logic [7:0]  cfg_or = '0, cfg_pol = '0;
    logic [15:0] in_vec = '0;
    logic        out_off = 1'b0;
    logic [7:0]  f_val, f_oe, oc_val, oc_oe;
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sop_logic_array u_sop_logic_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pol_sel(cfg_pol_sel),
        .cfg_lock(cfg_lock), .cfg_term(cfg_term), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .cfg_pol(cfg_pol), .in_vec(in_vec), .out_off(out_off), .f_val(f_val), .f_oe(f_oe));

    sop_logic_array #(.OPEN_COLL(1'b1)) u_oc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pol_sel(cfg_pol_sel),
        .cfg_lock(cfg_lock), .cfg_term(cfg_term), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .cfg_pol(cfg_pol), .in_vec(in_vec), .out_off(out_off), .f_val(oc_val), .f_oe(oc_oe));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_term(input logic [5:0] idx, input logic [31:0] a, input logic [7:0] o);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pol_sel = 1'b0; cfg_term = idx; cfg_and = a; cfg_or = o;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_pol(input logic [7:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pol_sel = 1'b1; cfg_pol = p;
        @(negedge clk);
        cfg_we = 1'b0; cfg_pol_sel = 1'b0;
    endtask

    task automatic apply(input logic [15:0] v);
        in_vec = v;
        #1;
    endtask

    task automatic t_reset;
        apply(16'h0000); chk("R1 zeros", f_val, 8'h00);
        apply(16'hFFFF); chk("R1 ones", f_val, 8'h00);
        apply(16'hA5C3); chk("R1 mixed", f_val, 8'h00);
        chk("R1 oe", f_oe, 8'hFF);
    endtask

    task automatic t_and_codes;
        // term0: input0 true-only (bits 1:0 = 01), input1 complement-only (bits 3:2 = 10)
        wr_term(6'd0, 32'h0000_0009, 8'h01);
        apply(16'h0001); chk("R2 match", f_val, 8'h01);
        apply(16'h0003); chk("R2 comp miss", f_val, 8'h00);
        apply(16'h0000); chk("R2 true miss", f_val, 8'h00);
        apply(16'hFFF1); chk("R2 dont care", f_val, 8'h01);
    endtask

    task automatic t_or_route;
        wr_term(6'd1, 32'h0000_0000, 8'h02);
        apply(16'h0000); chk("R4 all blown term", f_val, 8'h02);
        apply(16'h0001); chk("R4 two terms", f_val, 8'h03);
    endtask

    task automatic t_dead;
        wr_term(6'd2, 32'h0000_000C, 8'h04);
        apply(16'h0002); chk("R3 dead hi", f_val, 8'h02);
        apply(16'h0000); chk("R3 dead lo", f_val, 8'h02);
    endtask

    task automatic t_polarity;
        wr_pol(8'h80);
        apply(16'h0001); chk("R5 active low", f_val, 8'h83);
        wr_term(6'd3, 32'h0000_0000, 8'h10);
        apply(16'h0001); chk("R9 pol kept", f_val, 8'h93);
        wr_pol(8'h80);
        apply(16'h0001); chk("R9 links kept", f_val, 8'h93);
    endtask

    task automatic t_lock;
        cfg_lock = 1'b1;
        wr_term(6'd4, 32'h0000_0000, 8'h20);
        wr_pol(8'h00);
        apply(16'h0001); chk("R7 locked", f_val, 8'h93);
        cfg_lock = 1'b0;
    endtask

    task automatic t_index;
        wr_term(6'd50, 32'h0000_0000, 8'h40);
        apply(16'h0001); chk("R8 idx 50", f_val, 8'h93);
        wr_term(6'd47, 32'h0000_0000, 8'h40);
        apply(16'h0001); chk("R8 idx 47", f_val, 8'hD3);
    endtask

    task automatic t_comb;
        // R10: no clock edge between the input change and the check
        @(posedge clk);
        #0.5 in_vec = 16'h0003;
        #0.5 chk("R10 falls", f_val, 8'hD2);
        in_vec = 16'h0001;
        #0.5 chk("R10 rises", f_val, 8'hD3);
    endtask

    task automatic t_disable;
        @(negedge clk);
        out_off = 1'b1;
        #1;
        chk("R6 tri oe", f_oe, 8'h00);
        chk("R6 tri val", f_val, 8'h00);
        chk("R6 oc oe", oc_oe, 8'h00);
        chk("R6 oc val", oc_val, 8'hFF);
        out_off = 1'b0;
        #1;
        chk("R6 re-enable", f_val, 8'hD3);
        chk("R6 oc same logic", oc_val, 8'hD3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_and_codes;
        t_or_route;
        t_dead;
        t_polarity;
        t_lock;
        t_index;
        t_comb;
        t_disable;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule